// File: doc/BRIEF.md
# Zero-Address Stack Processor Core

This block is a small processor in which arithmetic names no operands at all. Values live on an internal operand stack that is reached only through its top. A load-type instruction copies a word from data memory onto the stack, and a store-type instruction moves the top word back out. Each arithmetic instruction consumes the two uppermost entries and leaves a single result in their place.

Every instruction is one 32-bit word. The upper byte selects the operation and the lower 24 bits hold a memory address, which is used by the memory and jump instructions. Instructions are fetched from a synchronous instruction memory at the program counter. Each instruction takes exactly four clock cycles: fetch, decode, memory access and writeback. Both memories have a read latency of one cycle. A halt instruction, or any stack fault or undefined opcode, stops the core. A fault also sets a sticky error flag. Both stay set until reset.

The reset input is asynchronous and active low. The core releases it internally through a two-stage synchronizer.

Top module: `stack_core`

## Requirements
- R1: The instruction layout is opcode in bits [31:24] and address in bits [23:0]. The instruction at `imem_addr` (the program counter) is used. Every instruction takes four cycles. The counter advances by one after each instruction that is not a jump.
- R2: Opcode 0x01 (load) reads data memory at the address field and pushes the word read onto the stack.
- R3: Opcode 0x02 (store) writes the top entry to data memory at the address field and removes that entry.
- R4: Opcodes 0x10 (add) and 0x12 (multiply) replace the two top entries with the low 32 bits of their sum or product. The stack shrinks by one.
- R5: Opcode 0x11 computes second-from-top minus top. Opcode 0x13 computes the unsigned quotient of second-from-top divided by top. A zero divisor gives all ones.
- R6: Opcode 0x20 loads the program counter from the address field.
- R7: Opcode 0xFF raises `halted`. After that no memory strobe is driven, and the program counter holds the address of the halt instruction.
- R8: The stack holds 8 entries. The following instructions are faults:
  - a load on a full stack;
  - a store on an empty stack;
  - an arithmetic instruction with fewer than two entries.
  A fault sets the sticky `stack_err` and raises `halted`. It performs no memory access, and it leaves the program counter at the faulting instruction.
- R9: Any opcode not listed above is treated as a fault, exactly as in R8.
- R10: While reset is asserted, `halted`, `stack_err`, `dmem_re` and `dmem_we` are 0 and `imem_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 24 | Program counter, address to instruction memory |
| imem_rdata | input | 32 | Instruction word, one cycle after the address |
| dmem_addr | output | 24 | Data memory address |
| dmem_re | output | 1 | Data read strobe |
| dmem_we | output | 1 | Data write strobe |
| dmem_wdata | output | 32 | Data written on a store |
| dmem_rdata | input | 32 | Data read, one cycle after the strobe |
| halted | output | 1 | Core stopped, by halt or by fault |
| stack_err | output | 1 | Sticky stack or opcode fault |

## Verification
The bench targets the following corner cases, each with the failure it would expose:
- **Operand order of subtraction and division.** A core that swaps the two top entries returns a negated difference or a wrong quotient on the nested expression.
- **Stack boundaries.** Filling exactly eight entries must run clean, while a ninth load must fault. A one-off count check either faults early or corrupts data silently.
- **Under-filled stack.** An arithmetic or store instruction on too few entries must halt, with no stray write.
- **Division by zero.** The zero-divisor case must yield all ones.
- **Jump.** A jump that skips a store must produce no write.
- **Instruction timing.** The cycle count of a known program must match four cycles per instruction.

// File: rtl/stack_core_pkg.sv
package stack_core_pkg;
  localparam int OP_W = 8;

  localparam logic [OP_W-1:0] OP_LOAD  = 8'h01;
  localparam logic [OP_W-1:0] OP_STORE = 8'h02;
  localparam logic [OP_W-1:0] OP_ADD   = 8'h10;
  localparam logic [OP_W-1:0] OP_SUB   = 8'h11;
  localparam logic [OP_W-1:0] OP_MUL   = 8'h12;
  localparam logic [OP_W-1:0] OP_DIV   = 8'h13;
  localparam logic [OP_W-1:0] OP_JUMP  = 8'h20;
  localparam logic [OP_W-1:0] OP_HALT  = 8'hFF;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_DECODE,
    ST_MEM,
    ST_WB,
    ST_HALT
  } core_state_e;

  typedef enum logic [1:0] {
    SK_NONE,
    SK_PUSH,
    SK_POP,
    SK_FOLD
  } stack_op_e;
endpackage

// File: rtl/stack_alu.sv
module stack_alu
  import stack_core_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [OP_W-1:0] sel,
  input  logic [W-1:0]    lhs,
  input  logic [W-1:0]    rhs,
  output logic [W-1:0]    y
);
  always_comb begin
    case (sel)
      OP_ADD:  y = lhs + rhs;
      OP_SUB:  y = lhs - rhs;
      OP_MUL:  y = lhs * rhs;
      OP_DIV:  y = (rhs == '0) ? '1 : lhs / rhs;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/op_stack.sv
module op_stack
  import stack_core_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  stack_op_e                  op,
  input  logic [W-1:0]               wdata,
  output logic [W-1:0]               top,
  output logic [W-1:0]               second,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]     slot_q [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] top_idx, sec_idx, wr_idx;
  logic             wr_en;

  assign top_idx = IDX_W'(cnt_q - CNT_W'(1));
  assign sec_idx = IDX_W'(cnt_q - CNT_W'(2));
  assign top     = slot_q[top_idx];
  assign second  = slot_q[sec_idx];
  assign count   = cnt_q;

  always_comb begin
    cnt_d  = cnt_q;
    wr_en  = 1'b0;
    wr_idx = IDX_W'(cnt_q);
    case (op)
      SK_PUSH: begin
        cnt_d = cnt_q + CNT_W'(1);
        wr_en = 1'b1;
      end
      SK_POP:  cnt_d = cnt_q - CNT_W'(1);
      SK_FOLD: begin
        cnt_d  = cnt_q - CNT_W'(1);
        wr_en  = 1'b1;
        wr_idx = sec_idx;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) slot_q[wr_idx] <= wdata;
  end

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (op == SK_PUSH) |-> (cnt_q < CNT_W'(DEPTH)));
  a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (op == SK_POP) |-> (cnt_q != '0));
  a_r4_fold_needs_two: assert property (@(posedge clk) disable iff (!rst_n)
    (op == SK_FOLD) |-> (cnt_q >= CNT_W'(2)));
  a_r2_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (op == SK_PUSH) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/stack_core.sv
module stack_core
  import stack_core_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 24,
  parameter int DEPTH  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  output logic [ADDR_W-1:0]      imem_addr,
  input  logic [OP_W+ADDR_W-1:0] imem_rdata,
  output logic [ADDR_W-1:0]      dmem_addr,
  output logic                   dmem_re,
  output logic                   dmem_we,
  output logic [DATA_W-1:0]      dmem_wdata,
  input  logic [DATA_W-1:0]      dmem_rdata,
  output logic                   halted,
  output logic                   stack_err
);
  localparam int INSTR_W = OP_W + ADDR_W;
  localparam int CNT_W   = $clog2(DEPTH+1);

  logic                rs_meta_q, rs_q;
  core_state_e         state_q, state_d;
  logic [ADDR_W-1:0]   pc_q, pc_d;
  logic [INSTR_W-1:0]  ir_q;
  logic                ir_en;
  logic                err_q, err_d;
  logic [OP_W-1:0]     opc;
  logic [ADDR_W-1:0]   fld;
  logic                is_arith, fault;
  stack_op_e           sk_op;
  logic [DATA_W-1:0]   sk_wdata, sk_top, sk_second, alu_y;
  logic [CNT_W-1:0]    sk_count;

  // reset: asserted at once, released through two flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      rs_q      <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rs_q      <= rs_meta_q;
    end
  end

  assign opc      = ir_q[INSTR_W-1 -: OP_W];
  assign fld      = ir_q[ADDR_W-1:0];
  assign is_arith = (opc == OP_ADD) || (opc == OP_SUB) ||
                    (opc == OP_MUL) || (opc == OP_DIV);

  always_comb begin
    if (opc == OP_LOAD)                          fault = (sk_count == CNT_W'(DEPTH));
    else if (opc == OP_STORE)                    fault = (sk_count == '0);
    else if (is_arith)                           fault = (sk_count < CNT_W'(2));
    else if ((opc == OP_JUMP) || (opc == OP_HALT)) fault = 1'b0;
    else                                         fault = 1'b1;
  end

  // next-state logic
  always_comb begin
    state_d  = state_q;
    pc_d     = pc_q;
    err_d    = err_q;
    ir_en    = 1'b0;
    sk_op    = SK_NONE;
    sk_wdata = alu_y;
    dmem_re  = 1'b0;
    dmem_we  = 1'b0;
    case (state_q)
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: begin
        ir_en   = 1'b1;
        state_d = ST_MEM;
      end
      ST_MEM: begin
        if (fault) begin
          err_d   = 1'b1;
          state_d = ST_HALT;
        end else if (opc == OP_HALT) begin
          state_d = ST_HALT;
        end else begin
          dmem_re = (opc == OP_LOAD);
          dmem_we = (opc == OP_STORE);
          state_d = ST_WB;
        end
      end
      ST_WB: begin
        if (opc == OP_LOAD) begin
          sk_op    = SK_PUSH;
          sk_wdata = dmem_rdata;
        end else if (opc == OP_STORE) begin
          sk_op = SK_POP;
        end else if (is_arith) begin
          sk_op = SK_FOLD;
        end
        pc_d    = (opc == OP_JUMP) ? fld : pc_q + ADDR_W'(1);
        state_d = ST_FETCH;
      end
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rs_q) begin
    if (!rs_q) begin
      state_q <= ST_FETCH;
      pc_q    <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ir_en) ir_q <= imem_rdata;
  end

  op_stack #(.W(DATA_W), .DEPTH(DEPTH)) u_stack (
    .clk    (clk),
    .rst_n  (rs_q),
    .op     (sk_op),
    .wdata  (sk_wdata),
    .top    (sk_top),
    .second (sk_second),
    .count  (sk_count)
  );

  stack_alu #(.W(DATA_W)) u_alu (
    .sel (opc),
    .lhs (sk_second),
    .rhs (sk_top),
    .y   (alu_y)
  );

  assign imem_addr  = pc_q;
  assign dmem_addr  = fld;
  assign dmem_wdata = sk_top;
  assign halted     = (state_q == ST_HALT);
  assign stack_err  = err_q;

  a_r7_halt_quiet: assert property (@(posedge clk) disable iff (!rs_q)
    halted |-> (!dmem_we && !dmem_re));
  a_r7_pc_hold: assert property (@(posedge clk) disable iff (!rs_q)
    halted |=> $stable(imem_addr));
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rs_q)
    stack_err |=> stack_err);
  a_r8_err_halts: assert property (@(posedge clk) disable iff (!rs_q)
    stack_err |-> halted);
  a_r2_rw_exclusive: assert property (@(posedge clk) disable iff (!rs_q)
    !(dmem_we && dmem_re));
  a_r1_pc_steady_in_decode: assert property (@(posedge clk) disable iff (!rs_q)
    (state_q == ST_DECODE) |=> $stable(imem_addr));
endmodule

// File: tb/stack_core_bench.sv
module stack_core_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] imem_addr, dmem_addr;
  logic [31:0] imem_rdata, dmem_wdata, dmem_rdata;
  logic        dmem_re, dmem_we, halted, stack_err;

  logic [31:0] imem [64];
  logic [31:0] dmem [256];
  logic [23:0] exp_addr_q[$];
  logic [31:0] exp_data_q[$];
  int          n_checks = 0;
  int          n_fail   = 0;
  int          cyc_total = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stack_core u_stack_core (
    .clk(clk), .rst_n(rst_n),
    .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_re(dmem_re), .dmem_we(dmem_we),
    .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
    .halted(halted), .stack_err(stack_err)
  );

  // synchronous memory models, one cycle of read latency
  always @(posedge clk) begin
    imem_rdata <= imem[imem_addr[5:0]];
    if (dmem_re) dmem_rdata <= dmem[dmem_addr[7:0]];
    if (dmem_we) dmem[dmem_addr[7:0]] <= dmem_wdata;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic expect_write(input logic [23:0] a, input logic [31:0] d);
    exp_addr_q.push_back(a);
    exp_data_q.push_back(d);
  endtask

  // monitor: every write strobe is compared with the next expected item
  always @(negedge clk) begin
    if (rst_n && dmem_we) begin
      if (exp_addr_q.size() == 0) begin
        chk(1'b0, "R3 unexpected write", {8'h0, dmem_addr}, 32'h0);
      end else begin
        logic [23:0] ea;
        logic [31:0] ed;
        ea = exp_addr_q.pop_front();
        ed = exp_data_q.pop_front();
        chk(dmem_addr == ea, "R3 store address", {8'h0, dmem_addr}, {8'h0, ea});
        chk(dmem_wdata == ed, "R4 R5 store data", dmem_wdata, ed);
      end
    end
  end

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 150000) begin
      chk(1'b0, "watchdog", cyc_total, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  function automatic logic [31:0] ins(input logic [7:0] op, input logic [23:0] a);
    return {op, a};
  endfunction

  task automatic start_prog();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 64; i++) imem[i] = 32'h5500_0000;
    dmem[8'h10] = 32'd5;   // A
    dmem[8'h11] = 32'd7;   // B
    dmem[8'h12] = 32'd3;   // C
    dmem[8'h13] = 32'd100;
    dmem[8'h14] = 32'd0;
  endtask

  task automatic run_prog(output int cyc);
    @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    while (!halted && cyc < 2000) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic finish_prog(input string tag, input bit exp_err, input logic [23:0] exp_pc);
    logic [23:0] pc_now;
    chk(halted == 1'b1, {tag, " halted"}, halted, 1);
    chk(stack_err == exp_err, {tag, " stack_err"}, stack_err, exp_err);
    chk(imem_addr == exp_pc, {tag, " pc"}, imem_addr, exp_pc);
    pc_now = imem_addr;
    repeat (5) @(negedge clk);
    chk(imem_addr == pc_now && halted, "R7 pc holds after stop", imem_addr, pc_now);
    chk(exp_addr_q.size() == 0, {tag, " pending writes"}, exp_addr_q.size(), 0);
    exp_addr_q.delete();
    exp_data_q.delete();
  endtask

  initial begin
    int cyc;
    // R10 reset state
    start_prog();
    repeat (3) @(negedge clk);
    chk(halted == 0 && stack_err == 0, "R10 flags in reset", {halted, stack_err}, 0);
    chk(dmem_we == 0 && dmem_re == 0, "R10 strobes in reset", {dmem_we, dmem_re}, 0);
    chk(imem_addr == 0, "R10 pc in reset", imem_addr, 0);

    // program 1: expression, operand order, divide, jump, halt
    start_prog();
    imem[0]  = ins(8'h01, 24'h10); imem[1]  = ins(8'h01, 24'h11); imem[2]  = ins(8'h12, 0);
    imem[3]  = ins(8'h01, 24'h10); imem[4]  = ins(8'h01, 24'h12); imem[5]  = ins(8'h01, 24'h11);
    imem[6]  = ins(8'h12, 0);      imem[7]  = ins(8'h10, 0);      imem[8]  = ins(8'h11, 0);
    imem[9]  = ins(8'h02, 24'h40);
    imem[10] = ins(8'h01, 24'h10); imem[11] = ins(8'h01, 24'h11); imem[12] = ins(8'h11, 0);
    imem[13] = ins(8'h02, 24'h41);
    imem[14] = ins(8'h01, 24'h13); imem[15] = ins(8'h01, 24'h11); imem[16] = ins(8'h13, 0);
    imem[17] = ins(8'h02, 24'h42);
    imem[18] = ins(8'h01, 24'h11); imem[19] = ins(8'h01, 24'h14); imem[20] = ins(8'h13, 0);
    imem[21] = ins(8'h02, 24'h43);
    imem[22] = ins(8'h20, 24'd24); imem[23] = ins(8'h02, 24'h44);
    imem[24] = ins(8'hFF, 0);
    expect_write(24'h40, 32'd9);            // R4 R5: 5*7-(5+3*7)
    expect_write(24'h41, 32'hFFFF_FFFE);    // R5: 5-7
    expect_write(24'h42, 32'd14);           // R5: 100/7
    expect_write(24'h43, 32'hFFFF_FFFF);    // R5: divide by zero
    run_prog(cyc);
    chk(cyc == 2 + 4*23 + 3, "R1 four cycles per instruction", cyc, 2 + 4*23 + 3);
    finish_prog("R6 R7 program one", 1'b0, 24'd24);
    chk(dmem[8'h40] == 32'd9, "R3 stored result in memory", dmem[8'h40], 32'd9);

    // program 2: exactly eight entries, folded and stored
    start_prog();
    for (int i = 0; i < 8; i++) imem[i] = ins(8'h01, 24'h10);
    for (int i = 8; i < 15; i++) imem[i] = ins(8'h10, 0);
    imem[15] = ins(8'h02, 24'h45);
    imem[16] = ins(8'hFF, 0);
    expect_write(24'h45, 32'd40);
    run_prog(cyc);
    finish_prog("R8 full stack no fault", 1'b0, 24'd16);

    // program 3: ninth load overflows
    start_prog();
    for (int i = 0; i < 9; i++) imem[i] = ins(8'h01, 24'h10);
    imem[9] = ins(8'h02, 24'h46);
    run_prog(cyc);
    finish_prog("R8 overflow", 1'b1, 24'd8);

    // program 4: arithmetic on one entry
    start_prog();
    imem[0] = ins(8'h01, 24'h10);
    imem[1] = ins(8'h10, 0);
    imem[2] = ins(8'h02, 24'h47);
    run_prog(cyc);
    finish_prog("R8 arith underflow", 1'b1, 24'd1);

    // program 5: store on empty stack
    start_prog();
    imem[0] = ins(8'h02, 24'h48);
    run_prog(cyc);
    finish_prog("R8 store underflow", 1'b1, 24'd0);

    // program 6: undefined opcode after a valid store
    start_prog();
    imem[0] = ins(8'h01, 24'h11);
    imem[1] = ins(8'h02, 24'h49);
    imem[2] = ins(8'h55, 24'h49);
    expect_write(24'h49, 32'd7);
    run_prog(cyc);
    finish_prog("R9 undefined opcode", 1'b1, 24'd2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule